// File: doc/BRIEF.md
# Selectable DC-Removal Highpass Filter

This block strips the DC offset from a stream of signed 24-bit PCM samples on an audio record path. Each time the input strobe is high it accepts one sample and, one clock later, presents one filtered sample with its own strobe. The filter is first order, y[n] = x[n] − x[n−1] + a·y[n−1]. It has a zero at DC and a pole `a` chosen at run time from four values, each one minus a power of two. The feedback product is therefore a shift and a subtraction, with no multiplier.

The feedback state carries 12 fractional bits, so even the slowest pole settles to an exact zero output on a constant input. Results are rounded to the nearest integer and clamped to the signed 24-bit range. When the filter is disabled the samples pass through unchanged with the same latency. Any change of pole selection or enable clears the history, so a stale coefficient produces no transient.

Top module: `dc_block_hpf`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `out_data` keeps its value across cycles with `in_valid` low.
- R3: With `filt_en`=1 the output is round((x[n]−x[n−1])·2^12 + Y − floor(Y/2^k)) where Y is the stored state, scaled by 2^12. Rounding adds 2^11 and then takes the floor of the division by 2^12. The pole shift k is 11 for `pole_sel`=0, 5 for 1, 4 for 2 and 3 for 3.
- R4: The stored state is clamped to the 24-bit range in the scaled domain. The output is clamped to [−8388608, 8388607] instead of wrapping.
- R5: With `filt_en`=0, `out_data` equals the accepted `in_data` exactly, one cycle later.
- R6: After any change of `pole_sel` or `filt_en`, the previous input and the feedback state are treated as zero. The first filtered sample after the change therefore equals its input.
- R7: A constant input in any mode produces an output that decays to exactly 0 and stays there.
- R8: A sample that is not strobed neither changes the filter history nor produces an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | 1 = filter, 0 = bypass |
| pole_sel | input | 2 | Pole choice (shift 11, 5, 4, 3) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed filtered sample |

## Verification
A long constant input in each of the four modes shows the decay rate of each pole and confirms that the exact zero is reached. With the gentlest pole and a small step this is the case the fractional bits exist for. Full-scale samples alternating between extremes drive both clamps. A short bypass run separates pass-through from filtering. A random stream with gaps in the strobe, random pole changes and random enable toggles compares every sample against a bench model. That run tells apart stale-history bugs, a wrong shift per mode and rounding off by one.

// File: rtl/dc_block_hpf.sv
module dc_block_hpf #(
  parameter int DW  = 24,
  parameter int FB  = 12,
  parameter int SH0 = 11,
  parameter int SH1 = 5,
  parameter int SH2 = 4,
  parameter int SH3 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt_en,
  input  logic [1:0]    pole_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW = DW + FB + 2;
  localparam logic signed [AW-1:0] ACC_HI = {3'b000, {(DW+FB-1){1'b1}}};
  localparam logic signed [AW-1:0] ACC_LO = {3'b111, {(DW+FB-1){1'b0}}};
  localparam logic signed [AW-1:0] OUT_HI = {{(FB+3){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] HALF   = {{(AW-FB){1'b0}}, 1'b1, {(FB-1){1'b0}}};

  logic signed [DW-1:0] x_prev;
  logic signed [AW-1:0] y_acc;
  logic [1:0] sel_q;
  logic       en_q;

  wire restart = (pole_sel != sel_q) || (filt_en != en_q);
  wire signed [DW-1:0] xp_use = restart ? '0 : x_prev;
  wire signed [AW-1:0] y_use  = restart ? '0 : y_acc;

  logic signed [AW-1:0] y_shift;
  always_comb begin
    case (pole_sel)
      2'd0:    y_shift = y_use >>> SH0;
      2'd1:    y_shift = y_use >>> SH1;
      2'd2:    y_shift = y_use >>> SH2;
      default: y_shift = y_use >>> SH3;
    endcase
  end

  wire signed [AW-1:0] x_ext  = {{(AW-DW){in_data[DW-1]}}, in_data};
  wire signed [AW-1:0] xp_ext = {{(AW-DW){xp_use[DW-1]}}, xp_use};
  wire signed [AW-1:0] diff   = x_ext - xp_ext;
  wire signed [AW-1:0] acc_raw = (diff <<< FB) + y_use - y_shift;
  wire signed [AW-1:0] acc_sat = (acc_raw > ACC_HI) ? ACC_HI :
                                 (acc_raw < ACC_LO) ? ACC_LO : acc_raw;
  wire signed [AW-1:0] rounded = (acc_sat + HALF) >>> FB;
  wire signed [AW-1:0] y_clip  = (rounded > OUT_HI) ? OUT_HI : rounded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_prev    <= '0;
      y_acc     <= '0;
      sel_q     <= 2'd0;
      en_q      <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sel_q     <= pole_sel;
      en_q      <= filt_en;
      out_valid <= in_valid;
      if (restart) begin
        x_prev <= '0;
        y_acc  <= '0;
      end
      if (in_valid && filt_en) begin
        x_prev <= in_data;
        y_acc  <= acc_sat;
      end
      if (in_valid)
        out_data <= filt_en ? y_clip[DW-1:0] : in_data;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filt_en) |=> out_data == $past(in_data));
  // R6
  restart_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && filt_en && restart) |=> out_data == $past(in_data));
  // R4
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_acc <= ACC_HI) && (y_acc >= ACC_LO));
endmodule

// File: tb/dc_block_hpf_tb.sv
module dc_block_hpf_tb;
  localparam int CLK_NS = 10;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic clk = 0, rst_n = 0, filt_en = 1, in_valid = 0;
  logic [1:0] pole_sel = 0;
  logic [23:0] in_data = 0;
  logic out_valid;
  logic [23:0] out_data;
  int errors = 0, checks = 0;

  longint m_xp = 0, m_y = 0;
  logic [1:0] m_sel = 0;
  logic m_en = 1;

  always #(CLK_NS/2) clk = ~clk;

  dc_block_hpf u_dut (.clk(clk), .rst_n(rst_n), .filt_en(filt_en), .pole_sel(pole_sel),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  function automatic int shift_of(logic [1:0] s);
    case (s) 2'd0: return 11; 2'd1: return 5; 2'd2: return 4; default: return 3; endcase
  endfunction

  function automatic longint model(longint x);
    longint acc, r;
    if (pole_sel != m_sel || filt_en != m_en) begin
      m_xp = 0; m_y = 0; m_sel = pole_sel; m_en = filt_en;
    end
    if (!filt_en) return x;
    acc = ((x - m_xp) <<< 12) + m_y - (m_y >>> shift_of(pole_sel));
    if (acc > ((MAXV <<< 12) + 4095)) acc = (MAXV <<< 12) + 4095;
    if (acc < (MINV <<< 12)) acc = MINV <<< 12;
    m_y = acc; m_xp = x;
    r = (acc + 2048) >>> 12;
    if (r > MAXV) r = MAXV;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  longint last_out;
  task automatic send(longint x, string req);
    logic signed [23:0] got;
    longint e;
    in_valid = 1; in_data = x[23:0];
    e = model(x);
    @(negedge clk);
    got = out_data;
    check({req, " valid"}, out_valid, 1);
    check(req, got, e);
    last_out = got;
    in_valid = 0;
  endtask

  task automatic idle(int n);
    logic [23:0] held;
    held = out_data;
    repeat (n) begin
      @(negedge clk);
      check("R8 no strobe", out_valid, 0);
      check("R2 hold", out_data, held);
    end
  endtask

  initial begin
    logic signed [23:0] r;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 data", out_data, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after", out_valid, 0);

    filt_en = 0;
    send(123456, "R5 bypass");
    send(-7, "R5 bypass");
    send(MINV, "R5 bypass");
    idle(2);

    for (int m = 0; m < 4; m++) begin
      longint d = (m == 0) ? 1000 : 300000;
      int n = (m == 0) ? 18000 : 600;
      filt_en = 1; pole_sel = m[1:0];
      send(d, "R6 first after change");
      check("R6 equals input", last_out, d);
      for (int i = 1; i < n; i++) send(d, "R3 dc");
      check("R7 decayed to zero", last_out, 0);
      send(d, "R7 stays zero");
      check("R7 stays zero", last_out, 0);
      pole_sel = m[1:0] ^ 2'd1;
      send(0, "R6 change");
      pole_sel = m[1:0];
    end

    pole_sel = 3;
    send(0, "R6");
    for (int i = 0; i < 4; i++) begin
      send(MAXV, "R4 sat");
      check("R4 top", last_out, MAXV);
      send(MINV, "R4 sat");
      check("R4 bottom", last_out, MINV);
    end

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) < 3) pole_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 2) filt_en = ~filt_en;
      r = 24'($urandom);
      if ($urandom_range(0, 3) != 0) r = r >>> 8;
      send(r, "R3 random");
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule